// File: doc/BRIEF.md
# Sync-Locked Display Window Timer

This block produces the horizontal and vertical display-active windows for an on-screen display. It does not generate its own raster. Both windows are slaved to horizontal and vertical sync pulses that come from outside the chip, for example from the scan circuits of a picture tube. Each sync input has its own polarity select. Each input passes through a synchroniser before its leading edge is detected.

The pixel counter restarts on every horizontal leading edge. The line counter restarts on every vertical leading edge and advances once per horizontal leading edge. Neither counter wraps at a fixed total, so the timer follows rasters of any field length, including 525-line and 625-line systems. A user feeds the outputs (window flags plus a pixel index and a line index inside the window) to a character or pixel generator.

With the defaults, the clock is 10 MHz. The horizontal window opens 172 clocks after the detected edge and lasts 400 clocks. The vertical window covers lines 41 to 290 of a field, counting the line that starts at vertical sync as line 1.

Top module: `sync_window_timer`

## Requirements
- R1: A polarity input of 0 makes a low-to-high transition of the sync input its leading edge. A polarity input of 1 makes a high-to-low transition the leading edge.
- R2: Only the leading edge of a horizontal pulse matters. The pulse width has no effect on `h_active` or `pix_x`.
- R3: Number the rising clock edges, with edge 1 being the first edge at which the horizontal input shows its active level. With the defaults, `h_active` is 1 from edge 175 through edge 574 and is 0 at every other edge of that line.
- R4: While `h_active` is 1, `pix_x` runs 0, 1, … up to 399, advancing by one per clock. While `h_active` is 0, `pix_x` is 0.
- R5: A horizontal leading edge that arrives while the window is open closes the window and restarts the timing from count 0.
- R6: Without further horizontal edges, the pixel counter saturates and never wraps, so the window stays closed.
- R7: After a vertical leading edge, the line count L is 0, and each horizontal leading edge raises it by 1. `v_active` is 1 for 40 ≤ L < 290, and then `line_y` = L − 40. Otherwise `line_y` is 0. Both outputs update at the same clock edge as the horizontal restart.
- R8: A vertical edge that arrives before line 290 closes the vertical window early.
- R9: When vertical and horizontal leading edges are detected in the same clock, the vertical edge wins. The line count becomes 0, not the incremented value.
- R10: Without further vertical edges, the line count saturates and never wraps, so the vertical window never reopens.
- R11: After synchronous reset, and until the first sync edges, both windows are closed and both indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (default 10 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync from the deflection circuit (asynchronous) |
| vsync_in | input | 1 | Vertical sync from the deflection circuit (asynchronous) |
| hsync_neg | input | 1 | Horizontal polarity: 0 = high-going pulse, 1 = low-going pulse |
| vsync_neg | input | 1 | Vertical polarity: 0 = high-going pulse, 1 = low-going pulse |
| h_active | output | 1 | Horizontal display window open |
| v_active | output | 1 | Vertical display window open |
| pix_x | output | 9 | Pixel index within the horizontal window |
| line_y | output | 8 | Line index within the vertical window |

## Verification
A vertical leading edge and a horizontal leading edge can both reach the line counter in one clock, one asking for a reset and one asking for an advance. The bench provokes this by driving both sync inputs to their active level at the same clock, so both leading edges are detected in the same cycle after synchronisation. It judges the result in two ways. First, right after the pulse, the vertical window must be closed with `line_y` at 0. Second, exactly 40 further lines must be needed to open the vertical window, which shows that the count started from zero and not from one.

// File: rtl/sync_window_pkg.sv
package sync_window_pkg;

  // Converts a duration in nanoseconds into whole clock cycles for a clock in kHz.
  function automatic int unsigned ns_to_clk(input int unsigned clk_khz, input int unsigned dur_ns);
    return (clk_khz * dur_ns) / 1_000_000;
  endfunction

endpackage

// File: rtl/sync_edge_detect.sv
module sync_edge_detect #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic active_low,
  output logic lead_edge
);

  logic [STAGES-1:0] sync_q;
  logic              norm;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[STAGES-2:0], sync_in};
  end

  // Polarity is normalised after the synchroniser, so an active pulse always reads as 1.
  assign norm = sync_q[STAGES-1] ^ active_low;

  // Starting at 1 blocks a false edge right after reset.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= norm;
  end

  assign lead_edge = norm & ~prev_q;

  // R2: a leading edge is a single-cycle event, whatever the pulse width.
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    lead_edge |=> !lead_edge);

endmodule

// File: rtl/sync_window_counter.sv
module sync_window_counter #(
  parameter int unsigned WIN_START = 172,
  parameter int unsigned WIN_LEN   = 400,
  parameter int unsigned CW        = 11,
  parameter int unsigned IW        = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          advance,
  output logic          win_active,
  output logic [IW-1:0] win_index
);

  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [CW-1:0] WIN_LO  = CW'(WIN_START);
  localparam logic [CW-1:0] WIN_HI  = CW'(WIN_START + WIN_LEN);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          in_win;

  always_comb begin
    if (restart)                          cnt_d = '0;
    else if (advance && cnt_q != CNT_MAX) cnt_d = cnt_q + CW'(1);
    else                                  cnt_d = cnt_q;
    in_win = (cnt_d >= WIN_LO) && (cnt_d < WIN_HI);
  end

  // The counter resets to saturation, so the window stays shut until the first restart.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= CNT_MAX;
      win_active <= 1'b0;
      win_index  <= '0;
    end else begin
      cnt_q      <= cnt_d;
      win_active <= in_win;
      win_index  <= in_win ? IW'(cnt_d - WIN_LO) : '0;
    end
  end

  // R4 / R7: the index stays below the window length.
  a_r4_index_in_range: assert property (@(posedge clk) disable iff (rst)
    {1'b0, win_index} < (IW+1)'(WIN_LEN));

  // R4 / R7: the index is 0 while the window is closed.
  a_r4_closed_index_zero: assert property (@(posedge clk) disable iff (rst)
    !win_active |-> win_index == '0);

  // R4 / R7: the window opens at index 0.
  a_r4_open_at_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(win_active) |-> win_index == '0);

  // R4 / R7: inside an open window, the index moves by exactly the advance it was given.
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    win_active && $past(win_active) && !$past(restart)
      |-> win_index == $past(win_index) + IW'($past(advance)));

  // R6 / R10: a saturated counter stays saturated until a restart.
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) && !restart |=> cnt_q == CNT_MAX);

endmodule

// File: rtl/sync_window_timer.sv
module sync_window_timer #(
  parameter int unsigned CLK_KHZ      = 10_000,
  parameter int unsigned H_START_NS   = 17_200,
  parameter int unsigned H_LEN_NS     = 40_000,
  parameter int unsigned V_FIRST_LINE = 41,
  parameter int unsigned V_LINES      = 250,
  parameter int unsigned SYNC_STAGES  = 2,
  localparam int unsigned H_START = sync_window_pkg::ns_to_clk(CLK_KHZ, H_START_NS),
  localparam int unsigned H_LEN   = sync_window_pkg::ns_to_clk(CLK_KHZ, H_LEN_NS),
  localparam int unsigned V_START = V_FIRST_LINE - 1,
  localparam int unsigned HCW     = $clog2(H_START + H_LEN) + 1,
  localparam int unsigned LCW     = $clog2(V_START + V_LINES) + 1,
  localparam int unsigned PIX_W   = $clog2(H_LEN),
  localparam int unsigned LINE_W  = $clog2(V_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              hsync_neg,
  input  logic              vsync_neg,
  output logic              h_active,
  output logic              v_active,
  output logic [PIX_W-1:0]  pix_x,
  output logic [LINE_W-1:0] line_y
);

  // Channel 0 is horizontal, channel 1 is vertical.
  logic [1:0] raw_sync;
  logic [1:0] pol_neg;
  logic [1:0] lead;

  assign raw_sync = {vsync_in, hsync_in};
  assign pol_neg  = {vsync_neg, hsync_neg};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    sync_edge_detect #(.STAGES(SYNC_STAGES)) u_det (
      .clk        (clk),
      .rst        (rst),
      .sync_in    (raw_sync[g]),
      .active_low (pol_neg[g]),
      .lead_edge  (lead[g])
    );
  end

  // The pixel counter advances every clock and restarts on each horizontal edge.
  sync_window_counter #(
    .WIN_START (H_START),
    .WIN_LEN   (H_LEN),
    .CW        (HCW),
    .IW        (PIX_W)
  ) u_hwin (
    .clk        (clk),
    .rst        (rst),
    .restart    (lead[0]),
    .advance    (1'b1),
    .win_active (h_active),
    .win_index  (pix_x)
  );

  // The line counter advances on horizontal edges; a vertical edge restarts it and takes priority.
  sync_window_counter #(
    .WIN_START (V_START),
    .WIN_LEN   (V_LINES),
    .CW        (LCW),
    .IW        (LINE_W)
  ) u_vwin (
    .clk        (clk),
    .rst        (rst),
    .restart    (lead[1]),
    .advance    (lead[0]),
    .win_active (v_active),
    .win_index  (line_y)
  );

  // R9 and R8: a vertical edge always leaves the vertical window shut, even with a horizontal edge beside it.
  a_r9_vsync_wins: assert property (@(posedge clk) disable iff (rst)
    lead[1] |=> !v_active && line_y == '0);

  // R5: a horizontal edge always closes the horizontal window in the next cycle.
  a_r5_restart_closes: assert property (@(posedge clk) disable iff (rst)
    lead[0] |=> !h_active && pix_x == '0);

endmodule

// File: tb/sync_window_timer_tb.sv
module sync_window_timer_tb;

  localparam int HS = 172;
  localparam int HL = 400;
  localparam int VS = 40;
  localparam int VL = 250;
  localparam int LSAT = 1023;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hs_in = 1'b0;
  logic       vs_in = 1'b0;
  logic       hneg = 1'b0;
  logic       vneg = 1'b0;
  logic       h_active;
  logic       v_active;
  logic [8:0] pix_x;
  logic [7:0] line_y;

  int n_cmp = 0;
  int n_bad = 0;
  int vl = LSAT;  // expected line count since vertical sync (saturating)

  always #5 clk = ~clk;

  sync_window_timer u_dut (
    .clk(clk), .rst(rst), .hsync_in(hs_in), .vsync_in(vs_in),
    .hsync_neg(hneg), .vsync_neg(vneg),
    .h_active(h_active), .v_active(v_active), .pix_x(pix_x), .line_y(line_y)
  );

  function automatic int h_exp_act(input int c);
    return (c >= HS && c < HS + HL) ? 1 : 0;
  endfunction

  function automatic int h_exp_pix(input int c);
    return h_exp_act(c) != 0 ? c - HS : 0;
  endfunction

  function automatic int v_exp_act(input int l);
    return (l >= VS && l < VS + VL) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check_v(input string req);
    check({req, " v_active"}, int'(v_active), v_exp_act(vl));
    check({req, " line_y"}, int'(line_y), v_exp_act(vl) != 0 ? vl - VS : 0);
  endtask

  // One line of n clocks with a horizontal pulse w clocks wide. Edge d=1 first samples the active level.
  task automatic run_line(input int n, input int w, input bit chk_h, input string req);
    vl = (vl < LSAT) ? vl + 1 : LSAT;
    for (int d = 1; d <= n; d++) begin
      hs_in = (d <= w) ^ hneg;
      @(negedge clk);
      if (chk_h && d >= 3) begin
        check({req, " h_active"}, int'(h_active), h_exp_act(d - 3));
        check({req, " pix_x"}, int'(pix_x), h_exp_pix(d - 3));
      end
    end
    hs_in = hneg;
    check_v(req);
  endtask

  task automatic vsync_pulse(input bit with_h, input string req);
    for (int d = 1; d <= 8; d++) begin
      vs_in = (d <= 2) ^ vneg;
      hs_in = (with_h && d <= 2) ^ hneg;
      @(negedge clk);
    end
    vl = 0;
    check_v(req);
  endtask

  // The flip itself may look like an edge, so a vertical pulse follows to realign the line count.
  task automatic set_pol(input bit hn, input bit vn);
    hneg = hn; vneg = vn; hs_in = hn; vs_in = vn;
    repeat (6) @(negedge clk);
    vsync_pulse(1'b0, "R1");
  endtask

  initial begin
    #(10 * 190_000);
    n_bad++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state and quiet idle
    check("R11 h_active", int'(h_active), 0);
    check("R11 v_active", int'(v_active), 0);
    check("R11 pix_x", int'(pix_x), 0);
    check("R11 line_y", int'(line_y), 0);
    repeat (700) @(negedge clk);
    check("R11 idle h_active", int'(h_active), 0);

    // R3 R4: full line, positive polarity
    run_line(700, 5, 1'b1, "R3");
    // R2: a very short pulse and a very long one
    run_line(650, 1, 1'b1, "R2");
    run_line(650, 300, 1'b1, "R2");
    // R5: a short line cut off mid-window, then a normal line
    run_line(300, 4, 1'b1, "R5");
    run_line(620, 4, 1'b1, "R5");
    // R6: long line, counter saturates, window stays shut
    run_line(2600, 4, 1'b1, "R6");

    // R1: negative polarity on both inputs
    set_pol(1'b1, 1'b1);
    run_line(700, 8, 1'b1, "R1");
    set_pol(1'b0, 1'b0);

    // R7: a field long enough to open and close the vertical window
    vsync_pulse(1'b0, "R7");
    for (int i = 0; i < 300; i++) run_line(8, 2, 1'b0, "R7");
    // R8: early vertical sync inside the window
    vsync_pulse(1'b0, "R8");
    for (int i = 0; i < 100; i++) run_line(8, 2, 1'b0, "R8");
    vsync_pulse(1'b0, "R8");
    // R9: coincident edges, then 45 lines to reopen at exactly line 41
    for (int i = 0; i < 50; i++) run_line(8, 2, 1'b0, "R9");
    vsync_pulse(1'b1, "R9");
    for (int i = 0; i < 45; i++) run_line(8, 2, 1'b0, "R9");
    // R10: missing vertical sync, line count saturates
    for (int i = 0; i < 1100; i++) run_line(8, 2, 1'b0, "R10");

    // Random lines and polarities (R1 R2 R3 R4 R5)
    for (int k = 0; k < 6; k++) begin
      set_pol(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      for (int j = 0; j < 3; j++)
        run_line(int'($urandom_range(700, 150)), int'($urandom_range(30, 1)), 1'b1, "R4");
    end

    summary();
    $finish;
  end

endmodule